// File: doc/BRIEF.md
# NOR Flash Command Interface Emulator

This block is a synthesizable, device-side stand-in for a small parallel NOR flash. The storage array sits in on-chip registers. The block is driven by a simple synchronous bus with a chip enable, a write strobe, a read strobe, a word address, 16-bit write data and 16-bit read data.

Plain reads return array contents. Writes are never stored directly. A command decoder watches the sequence of bus writes and acts only on key-guarded command sequences:

- word program,
- whole-array erase,
- identification read,
- return to read mode.

A countdown timer stands in for the embedded program and erase algorithms. While it runs, every read returns a status word whose bit 7 tells the host whether the operation has finished.

Sector protection is a per-sector flag vector loaded from a parameter at reset. It cannot be changed afterwards.

Top module: `norflash_cmd_emu`

## Requirements
- R1: While `rst` is high at a clock edge, every array word becomes 0xFFFF, the block enters read mode with no operation running, and `rdata` becomes 0x0000.
- R2: A program runs after four accepted writes in a row:
  - 0x..AA to the first key address,
  - 0x..55 to the second key address,
  - 0x..A0 to the first key address,
  - then the target address with its data word.
  
  The key addresses are 0x555 and 0x2AA truncated to their low ADDR_W bits. Only the low data byte is compared.
- R3: A finished program leaves the target word equal to its old value AND the written data, so bits can only go from 1 to 0.
- R4: A program keeps the block busy for PGM_CYC clock edges, starting after the edge that accepted the final write. During that window any read returns a status word: bit 7 is the complement of bit 7 of the written data, and all other bits are 0. The first read after the window returns array data.
- R5: A whole-array erase starts after six writes: 0xAA and 0x55 to the two key addresses, 0x80 to the first key address, 0xAA and 0x55 again, then 0x10 to the first key address. On completion every word in an unprotected sector reads 0xFFFF. Words in protected sectors keep their values.
- R6: An erase keeps the block busy for ERA_CYC edges after the accepting edge. During that window reads return 0x0000, so bit 7 reads 0; afterwards reads return array data.
- R7: Writes accepted while an operation is running have no effect. This holds even for a complete command sequence.
- R8: A write that does not match the next expected step of a sequence returns the decoder to idle. That write is not re-examined as a first key write, and later steps issued without a fresh full sequence have no effect.
- R9: The sequence 0xAA, 0x55, then 0x90 to the first key address enters identification mode. In that mode, reads decode the address as follows: the sector is the top SECT_W address bits and the offset is the remaining low bits.
  - Offset 0 returns 0x0004.
  - Offset 1 returns 0x22C4.
  - Offset 2 returns the protection flag of the addressed sector on bit 0 (1 means protected), with the other bits 0.
  - Any other offset returns 0x0000.
- R10: Identification mode is left only by a write whose low data byte is 0xF0, at any address. Every other write, including key sequences, is ignored. Afterwards reads return array data, and the identification sequence can be issued again. An 0xF0 write in read mode changes nothing.
- R11: `rdata` takes the selected value on the clock edge where `ce` and `rd` are both high. On every other edge it keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Chip enable, qualifies both strobes |
| we | input | 1 | Write strobe; one bus write per edge with `ce` high |
| rd | input | 1 | Read strobe; one bus read per edge with `ce` high |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data; the low byte carries commands |
| rdata | output | 16 | Registered read data or status word |

## Verification
A read result appears on `rdata` one clock after the edge that samples the strobe. A busy window covers exactly the PGM_CYC or ERA_CYC edges that follow the edge accepting the final write.

The bench issues bus cycles back to back. Its first poll read is therefore sampled one edge after the final write, and every poll in the window is checked against the status word, as is the first data read after it. All `rdata` values are checked half a cycle after the edge that produced them.

Writes ignored during a busy window land inside it, so the reads that follow must still show status for exactly the cycles left in the window.

// File: rtl/nfe_pkg.sv
package nfe_pkg;

    // Command byte values (low data byte of a bus write)
    localparam logic [7:0] KEY_FIRST     = 8'hAA;
    localparam logic [7:0] KEY_SECOND    = 8'h55;
    localparam logic [7:0] CMD_PROGRAM   = 8'hA0;
    localparam logic [7:0] CMD_ERASE_ARM = 8'h80;
    localparam logic [7:0] CMD_ERASE_ALL = 8'h10;
    localparam logic [7:0] CMD_IDENT     = 8'h90;
    localparam logic [7:0] CMD_READ_MODE = 8'hF0;

    // Key addresses, truncated by the user to the address width
    localparam logic [15:0] KEY_ADDR_A = 16'h0555;
    localparam logic [15:0] KEY_ADDR_B = 16'h02AA;

    // Identification values
    localparam logic [15:0] ID_MAKER  = 16'h0004;
    localparam logic [15:0] ID_DEVICE = 16'h22C4;

    // Decoder position: names the step expected next
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_KEY2,
        SQ_COMMAND,
        SQ_PGM_DATA,
        SQ_ERA_KEY1,
        SQ_ERA_KEY2,
        SQ_ERA_CMD
    } seq_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PGM,
        OP_ERA
    } op_e;

    // Decoded view of one bus write
    typedef struct packed {
        logic       at_key_a;
        logic       at_key_b;
        logic [7:0] code;
    } wr_key_t;

    // Pending program request
    typedef struct packed {
        logic [15:0] data;
    } pgm_req_t;

    // Status word presented while an operation runs
    function automatic logic [15:0] status_word(input op_e kind, input logic bit7);
        logic [15:0] w;
        w = 16'h0000;
        if (kind == OP_PGM) w[7] = ~bit7;
        return w;
    endfunction

endpackage

// File: rtl/nfe_cmd_seq.sv
module nfe_cmd_seq
    import nfe_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_code,
    input  logic              busy,
    output op_e               start_op,
    output logic              id_mode
);

    localparam logic [ADDR_W-1:0] ADDR_A = KEY_ADDR_A[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] ADDR_B = KEY_ADDR_B[ADDR_W-1:0];

    seq_e    state, state_nx;
    logic    id_nx;
    wr_key_t key;

    always_comb begin
        key.at_key_a = (wr_addr == ADDR_A);
        key.at_key_b = (wr_addr == ADDR_B);
        key.code     = wr_code;
    end

    always_comb begin
        state_nx = state;
        id_nx    = id_mode;
        start_op = OP_NONE;
        if (busy) begin
            state_nx = SQ_IDLE;
        end else if (wr_en) begin
            state_nx = SQ_IDLE;
            if (id_mode) begin
                if (key.code == CMD_READ_MODE) id_nx = 1'b0;
            end else begin
                case (state)
                    SQ_IDLE:
                        if (key.at_key_a && key.code == KEY_FIRST) state_nx = SQ_KEY2;
                    SQ_KEY2:
                        if (key.at_key_b && key.code == KEY_SECOND) state_nx = SQ_COMMAND;
                    SQ_COMMAND:
                        if (key.at_key_a) begin
                            if (key.code == CMD_PROGRAM)        state_nx = SQ_PGM_DATA;
                            else if (key.code == CMD_ERASE_ARM) state_nx = SQ_ERA_KEY1;
                            else if (key.code == CMD_IDENT)     id_nx    = 1'b1;
                        end
                    SQ_PGM_DATA:
                        start_op = OP_PGM;
                    SQ_ERA_KEY1:
                        if (key.at_key_a && key.code == KEY_FIRST) state_nx = SQ_ERA_KEY2;
                    SQ_ERA_KEY2:
                        if (key.at_key_b && key.code == KEY_SECOND) state_nx = SQ_ERA_CMD;
                    SQ_ERA_CMD:
                        if (key.at_key_a && key.code == CMD_ERASE_ALL) start_op = OP_ERA;
                    default:
                        state_nx = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            id_mode <= 1'b0;
        end else begin
            state   <= state_nx;
            id_mode <= id_nx;
        end
    end

    // R10: identification mode persists across any non-exit write
    assert_id_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (id_mode && wr_en && wr_code != CMD_READ_MODE) |=> id_mode);

    // R7: a running operation parks the decoder in idle
    assert_busy_idle_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> (state == SQ_IDLE));

endmodule

// File: rtl/nfe_busy_timer.sv
module nfe_busy_timer
    import nfe_pkg::*;
#(
    parameter int PGM_CYC = 8,
    parameter int ERA_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  op_e  start_op,
    output logic busy,
    output logic done,
    output op_e  run_op
);

    localparam int MAXC = (PGM_CYC > ERA_CYC) ? PGM_CYC : ERA_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            run_op <= OP_NONE;
        end else if (start_op != OP_NONE) begin
            cnt    <= (start_op == OP_PGM) ? CW'(PGM_CYC) : CW'(ERA_CYC);
            run_op <= start_op;
        end else if (done) begin
            cnt    <= '0;
            run_op <= OP_NONE;
        end else if (busy) begin
            cnt    <= cnt - CW'(1);
        end
    end

    // R4: the count never exceeds the longest load value
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(MAXC));

    // R6: the completing edge always ends the busy window
    assert_done_clears_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R4: an operation kind is recorded whenever the block is busy
    assert_kind_known_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> run_op != OP_NONE);

endmodule

// File: rtl/nfe_array.sv
module nfe_array
    import nfe_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SECT_W = 2,
    parameter logic [(1<<SECT_W)-1:0] PROT_INIT = 4'b0100
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pgm_we,
    input  logic [ADDR_W-1:0]       pgm_addr,
    input  logic [15:0]             pgm_data,
    input  logic                    era_we,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [15:0]             rd_word,
    output logic [(1<<SECT_W)-1:0]  prot
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int NSECT = 1 << SECT_W;
    localparam int OFF_W = ADDR_W - SECT_W;

    logic [15:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) prot <= PROT_INIT;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        localparam int SEC = i >> OFF_W;
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= 16'hFFFF;
            end else if (era_we && !prot[SEC]) begin
                mem[i] <= 16'hFFFF;
            end else if (pgm_we && pgm_addr == ADDR_W'(i)) begin
                mem[i] <= mem[i] & pgm_data;
            end
        end
    end

    assign rd_word = mem[rd_addr];

    // R3: a committed program yields old AND new
    assert_pgm_and_R3: assert property (@(posedge clk) disable iff (rst)
        pgm_we |=> mem[$past(pgm_addr)] == ($past(mem[pgm_addr]) & $past(pgm_data)));

    // R5: erase fills unprotected sectors and leaves protected ones alone
    for (genvar s = 0; s < NSECT; s++) begin : g_era_chk
        localparam int FIRST = s << OFF_W;
        assert_erase_sector_R5: assert property (@(posedge clk) disable iff (rst)
            era_we |=> (prot[s] ? $stable(mem[FIRST]) : (mem[FIRST] == 16'hFFFF)));
    end

endmodule

// File: rtl/norflash_cmd_emu.sv
module norflash_cmd_emu
    import nfe_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int SECT_W  = 2,
    parameter int PGM_CYC = 8,
    parameter int ERA_CYC = 64,
    parameter logic [(1<<SECT_W)-1:0] PROT_INIT = 4'b0100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              we,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata
);

    localparam int OFF_W = ADDR_W - SECT_W;
    localparam int NSECT = 1 << SECT_W;

    logic              wr_en, rd_en;
    op_e               start_op, run_op;
    logic              id_mode, busy, done;
    pgm_req_t          req;
    logic [ADDR_W-1:0] req_addr;
    logic [15:0]       arr_word, id_word, rd_next;
    logic [NSECT-1:0]  prot;
    logic [SECT_W-1:0] sect;
    logic [OFF_W-1:0]  off;

    assign wr_en = ce & we;
    assign rd_en = ce & rd;
    assign sect  = addr[ADDR_W-1 -: SECT_W];
    assign off   = addr[OFF_W-1:0];

    nfe_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (addr),
        .wr_code  (wdata[7:0]),
        .busy     (busy),
        .start_op (start_op),
        .id_mode  (id_mode)
    );

    nfe_busy_timer #(.PGM_CYC(PGM_CYC), .ERA_CYC(ERA_CYC)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start_op (start_op),
        .busy     (busy),
        .done     (done),
        .run_op   (run_op)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req.data <= 16'hFFFF;
            req_addr <= '0;
        end else if (start_op == OP_PGM) begin
            req.data <= wdata;
            req_addr <= addr;
        end
    end

    nfe_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROT_INIT(PROT_INIT)) u_array (
        .clk      (clk),
        .rst      (rst),
        .pgm_we   (done && run_op == OP_PGM),
        .pgm_addr (req_addr),
        .pgm_data (req.data),
        .era_we   (done && run_op == OP_ERA),
        .rd_addr  (addr),
        .rd_word  (arr_word),
        .prot     (prot)
    );

    always_comb begin
        if (off == OFF_W'(0))      id_word = ID_MAKER;
        else if (off == OFF_W'(1)) id_word = ID_DEVICE;
        else if (off == OFF_W'(2)) id_word = {15'd0, prot[sect]};
        else                       id_word = 16'h0000;
    end

    always_comb begin
        if (busy)         rd_next = status_word(run_op, req.data[7]);
        else if (id_mode) rd_next = id_word;
        else              rd_next = arr_word;
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= 16'h0000;
        else if (rd_en) rdata <= rd_next;
    end

    // R4: program status shows the complement of the pending bit 7
    assert_pgm_status_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy && run_op == OP_PGM) |=> rdata == {8'h00, ~$past(req.data[7]), 7'h00});

    // R6: erase status reads all zero
    assert_era_status_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy && run_op == OP_ERA) |=> rdata == 16'h0000);

    // R7: the pending request cannot be overwritten while running
    assert_req_stable_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(req.data) && $stable(req_addr)));

    // R11: no read strobe, no change on the read bus
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

    // R9/R10: identification mode and busy are never both active
    assert_id_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
        !(id_mode && busy));

endmodule

// File: tb/norflash_cmd_emu_test.sv
module norflash_cmd_emu_test;

    localparam int AW    = 8;
    localparam int SW    = 2;
    localparam int PCYC  = 8;
    localparam int ECYC  = 64;
    localparam int DEPTH = 1 << AW;
    localparam logic [3:0] PROT = 4'b0100;
    localparam logic [7:0] KA = 8'h55;   // 0x555 low bits
    localparam logic [7:0] KB = 8'hAA;   // 0x2AA low bits

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce = 1'b0, we = 1'b0, rd = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [15:0] model [DEPTH];

    always #4 clk = ~clk;

    norflash_cmd_emu #(.ADDR_W(AW), .SECT_W(SW), .PGM_CYC(PCYC), .ERA_CYC(ECYC),
                       .PROT_INIT(PROT)) uut (
        .clk(clk), .rst(rst), .ce(ce), .we(we), .rd(rd),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        ce = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        ce = 1'b0; we = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [15:0] exp, input string req);
        ce = 1'b1; rd = 1'b1; addr = a;
        @(negedge clk);
        ce = 1'b0; rd = 1'b0;
        check(req, rdata, exp);
    endtask

    task automatic pgm_seq(input logic [7:0] a, input logic [15:0] d);
        wr(KA, 16'h00AA); wr(KB, 16'h0055); wr(KA, 16'h00A0); wr(a, d);
    endtask

    task automatic program_word(input logic [7:0] a, input logic [15:0] d);
        pgm_seq(a, d);
        for (int k = 0; k < PCYC; k++) rd_chk(a, {8'h00, ~d[7], 7'h00}, "R4 poll");
        model[a] = model[a] & d;
        rd_chk(a, model[a], "R3 result");
    endtask

    function automatic logic [15:0] id_expect(input int s, input int o);
        if (o == 0) return 16'h0004;
        if (o == 1) return 16'h22C4;
        if (o == 2) return {15'd0, PROT[s]};
        return 16'h0000;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rdata reset", rdata, 16'h0000);
        rst = 1'b0;

        // R1: whole array erased after reset
        for (int i = 0; i < DEPTH; i++) rd_chk(8'(i), 16'hFFFF, "R1 reset word");

        // R2 R3 R4: program sweep with varied patterns
        for (int i = 0; i < 12; i++) begin
            program_word(8'((i * 37 + 5) & 255), 16'(16'hA5C3 ^ (i * 16'h1357)));
        end

        // R3: second program only clears bits
        program_word(8'h40, 16'hF0F0);
        program_word(8'h40, 16'h3CFF);
        rd_chk(8'h40, 16'h30F0, "R3 and rule");

        // R7: full sequence during busy is ignored
        pgm_seq(8'h10, 16'h1234);
        pgm_seq(8'h20, 16'h0000);
        for (int k = 4; k < PCYC; k++) rd_chk(8'h10, 16'h0080, "R7 still busy");
        model[8'h10] = model[8'h10] & 16'h1234;
        rd_chk(8'h10, model[8'h10], "R7 first result");
        rd_chk(8'h20, model[8'h20], "R7 ignored target");

        // R8: broken sequences
        wr(KA, 16'h00AA); wr(KB, 16'h0055); wr(KA, 16'h00A5); wr(8'h30, 16'h0000);
        rd_chk(8'h30, model[8'h30], "R8 bad command");
        wr(KA, 16'h00AA); wr(KA, 16'h0055); wr(KA, 16'h00A0); wr(8'h31, 16'h0000);
        rd_chk(8'h31, model[8'h31], "R8 bad key address");
        wr(KA, 16'h00AA); wr(KB, 16'h0055); wr(KA, 16'h0080); wr(KA, 16'h00AA);
        wr(KB, 16'h0056); wr(KA, 16'h0010);
        rd_chk(8'h00, model[8'h00], "R8 broken erase");

        // R10: read-mode exit command does nothing in read mode
        wr(KA, 16'h00F0);
        rd_chk(8'h40, model[8'h40], "R10 F0 in read mode");

        // R11: read strobe without chip enable holds rdata
        ce = 1'b0; rd = 1'b1; addr = 8'h00;
        @(negedge clk);
        rd = 1'b0;
        check("R11 hold without ce", rdata, model[8'h40]);

        // R9: identification sweep
        wr(KA, 16'h00AA); wr(KB, 16'h0055); wr(KA, 16'h0090);
        for (int s = 0; s < 4; s++)
            for (int o = 0; o < 4; o++)
                rd_chk(8'((s << 6) | o), id_expect(s, o), "R9 id read");

        // R10: key sequences ignored in identification mode
        pgm_seq(8'h50, 16'h0000);
        rd_chk(8'h01, 16'h22C4, "R10 still id");
        wr(8'h77, 16'h12F0);
        rd_chk(8'h50, model[8'h50], "R10 exit");
        wr(KA, 16'h00AA); wr(KB, 16'h0055); wr(KA, 16'h0090);
        rd_chk(8'h00, 16'h0004, "R10 re-entry");
        wr(8'h00, 16'h00F0);
        rd_chk(8'h10, model[8'h10], "R10 second exit");

        // R5 R6: erase with a protected sector holding data
        program_word(8'h85, 16'h0F0F);
        program_word(8'h05, 16'h0000);
        wr(KA, 16'h00AA); wr(KB, 16'h0055); wr(KA, 16'h0080);
        wr(KA, 16'h00AA); wr(KB, 16'h0055); wr(KA, 16'h0010);
        for (int k = 0; k < ECYC; k++) rd_chk(8'h05, 16'h0000, "R6 erase poll");
        for (int i = 0; i < DEPTH; i++)
            if (!PROT[i >> 6]) model[i] = 16'hFFFF;
        for (int i = 0; i < DEPTH; i++) rd_chk(8'(i), model[i], "R5 after erase");

        // R3: erased bits can be cleared again
        program_word(8'h05, 16'h1111);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule